// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous dynamic RAM alive. After reset it holds the memory untouched for a start-up wait of more than 100 µs. It then runs eight dummy refresh cycles back to back, and only after those does it raise its init-done flag. From then on a periodic timer marks each refresh slot. Every slot adds one to a pending count, and a request to the access controller stays raised while that count is non-zero. When the controller grants the bus, the sequencer owns the row strobe, column strobe and address pins for one full refresh cycle and then gives them back. It pulses refresh-done at the end of every cycle.

A parameter picks one of two refresh styles. In the CAS-first style the column strobe falls before the row strobe and no address is driven. In the row-address style the column strobe stays high, an internal row counter is placed on the address pins, and the row strobe is pulsed. The counter steps after every cycle and wraps to zero. All delays are derived from the clock frequency parameter. The pending count does not lose a slot while the controller is busy, but it stops at a parameterised ceiling.

Top module: `drf_refresh_seq`

## Requirements
- R1: While reset is held, own_o, req_o, init_done_o, ref_done_o and addr_oe_o are 0, and ras_n_o and cas_n_o are 1.
- R2: The first strobe activity (own_o high) comes exactly CLK_MHZ*STARTUP_US+1 clock edges after reset is released. This is strictly more than STARTUP_US microseconds.
- R3: Exactly eight refresh cycles run before init_done_o rises. They need no grant, and req_o stays 0 until init_done_o is 1.
- R4: The first request rises exactly CLK_MHZ*REFRESH_NS/1000 edges after init_done_o rises, and later slots follow at the same spacing. That spacing is at most 15.6 µs, so 256 cycles fit in 4 ms.
- R5: A refresh cycle starts only on an edge where req_o and grant_i are both 1. Outside a cycle own_o is 0, both strobes are 1 and addr_oe_o is 0.
- R6: In the CAS-first style, cas_n_o is already low for at least one clock when ras_n_o falls, and addr_oe_o stays 0.
- R7: In the row-address style, cas_n_o is never low. When ras_n_o falls, addr_oe_o is 1 and addr_o carries the current row, which is stable from the cycle before.
- R8: The row counter starts at 0, steps by one after every refresh cycle, including the dummy cycles, and wraps from its all-ones value to 0.
- R9: ras_n_o stays low for exactly LOW_CYC clocks. Successive falls of ras_n_o are at least ceil(TRC_NS*CLK_MHZ/1000) clocks apart.
- R10: A slot that expires while a request is waiting is kept, not lost. This includes a slot expiring on the same edge a cycle starts. Each kept slot yields one cycle once grant_i is held.
- R11: The pending count saturates at PEND_MAX. After more than PEND_MAX slots expire without a grant, a held grant yields exactly PEND_MAX cycles.
- R12: ref_done_o is a one-clock pulse at the end of every refresh cycle, one per fall of ras_n_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, frequency CLK_MHZ |
| rst_ni | input | 1 | Active-low reset |
| grant_i | input | 1 | Controller hands the memory pins to the sequencer |
| req_o | output | 1 | At least one refresh slot is pending and the sequencer is idle |
| own_o | output | 1 | The sequencer drives the strobes and address this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ADDR_W | Row address in the row-address style, otherwise 0 |
| addr_oe_o | output | 1 | Drive enable for addr_o |
| init_done_o | output | 1 | Start-up wait and dummy cycles are complete |
| ref_done_o | output | 1 | One-clock pulse at the end of each refresh cycle |

## Verification
The slot timer and the grant path can act on the same edge. A slot may expire on exactly the edge where a granted cycle takes one slot from the pending count. The bench provokes this by raising grant one interval minus one clock after a request appears, so that the start edge and the next expiry coincide. It judges the result by counting two refresh-done pulses under a held grant, with the row address stepping once per pulse. Saturation is provoked the same way, by withholding grant across several expiries, and is judged by the length of the burst that follows.

// File: rtl/drf_pkg.sv
package drf_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_LEAD,
      ST_STROBE,
      ST_RECOV
   } seq_state_e;

   typedef enum logic {
      REF_CBR,
      REF_ROW
   } ref_style_e;

endpackage

// File: rtl/drf_interval_timer.sv
module drf_interval_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic tick_o
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   logic [CW-1:0] cnt_q;

   assign tick_o = en_i && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (!en_i || tick_o)   cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

   // two ticks never on adjacent edges (interval of at least two clocks)
   assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/drf_pending.sv
module drf_pending #(
   parameter int unsigned MAX = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic add_i,
   input  logic take_i,
   output logic nz_o
);
   localparam int unsigned CW = $clog2(MAX + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else begin
         unique case ({add_i, take_i})
            2'b10:   if (cnt_q != CW'(MAX)) cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign nz_o = (cnt_q != '0);

   assert_pend_cap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(MAX));

   assert_pend_sat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (add_i && !take_i && cnt_q == CW'(MAX)) |=> cnt_q == CW'(MAX));

   assert_take_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> cnt_q != '0);

   // simultaneous expiry and start leaves the count unchanged
   assert_add_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (add_i && take_i) |=> $stable(cnt_q));

endmodule

// File: rtl/drf_row_counter.sv
module drf_row_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   output logic [W-1:0] row_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    row_o <= '0;
      else if (inc_i) row_o <= row_o + 1'b1;
   end

   assert_row_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && row_o == '1) |=> row_o == '0);

   assert_row_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inc_i |=> $stable(row_o));

endmodule

// File: rtl/drf_cycle_fsm.sv
module drf_cycle_fsm
   import drf_pkg::*;
#(
   parameter ref_style_e  STYLE       = REF_ROW,
   parameter int unsigned LEAD_CYC    = 1,
   parameter int unsigned LOW_CYC     = 5,
   parameter int unsigned REC_CYC     = 4,
   parameter int unsigned INIT_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic boot_tick_i,
   input  logic grant_i,
   input  logic pend_nz_i,
   output logic booting_o,
   output logic req_o,
   output logic take_o,
   output logic cycle_end_o,
   output logic own_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic done_o,
   output logic init_done_o
);
   localparam int unsigned PH_W = $clog2(LEAD_CYC + LOW_CYC + REC_CYC + 1);
   localparam int unsigned DW   = $clog2(INIT_CYCLES + 1);

   seq_state_e      state_q, nxt;
   logic [PH_W-1:0] ph_q, ph_d;
   logic [DW-1:0]   dmy_q;
   logic            init_q, done_q, own_q, ras_n_q, cas_n_q;

   assign booting_o = (state_q == ST_BOOT);
   assign req_o     = (state_q == ST_IDLE) && pend_nz_i;
   assign take_o    = req_o && grant_i;

   always_comb begin
      nxt         = state_q;
      ph_d        = ph_q + 1'b1;
      cycle_end_o = 1'b0;
      unique case (state_q)
         ST_BOOT: begin
            ph_d = '0;
            if (boot_tick_i) nxt = ST_LEAD;
         end
         ST_IDLE: begin
            ph_d = '0;
            if (take_o) nxt = ST_LEAD;
         end
         ST_LEAD: if (ph_q == PH_W'(LEAD_CYC - 1)) begin
            nxt  = ST_STROBE;
            ph_d = '0;
         end
         ST_STROBE: if (ph_q == PH_W'(LOW_CYC - 1)) begin
            nxt  = ST_RECOV;
            ph_d = '0;
         end
         ST_RECOV: if (ph_q == PH_W'(REC_CYC - 1)) begin
            cycle_end_o = 1'b1;
            ph_d        = '0;
            nxt = (init_q || dmy_q == DW'(INIT_CYCLES - 1)) ? ST_IDLE : ST_LEAD;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_BOOT;
         ph_q    <= '0;
         dmy_q   <= '0;
         init_q  <= 1'b0;
         done_q  <= 1'b0;
         own_q   <= 1'b0;
         ras_n_q <= 1'b1;
         cas_n_q <= 1'b1;
      end else begin
         state_q <= nxt;
         ph_q    <= ph_d;
         done_q  <= cycle_end_o;
         if (cycle_end_o && !init_q) begin
            dmy_q <= dmy_q + 1'b1;
            if (dmy_q == DW'(INIT_CYCLES - 1)) init_q <= 1'b1;
         end
         own_q   <= (nxt == ST_LEAD) || (nxt == ST_STROBE) || (nxt == ST_RECOV);
         ras_n_q <= (nxt != ST_STROBE);
         cas_n_q <= !((STYLE == REF_CBR) && ((nxt == ST_LEAD) || (nxt == ST_STROBE)));
      end
   end

   assign own_o       = own_q;
   assign ras_n_o     = ras_n_q;
   assign cas_n_o     = cas_n_q;
   assign done_o      = done_q;
   assign init_done_o = init_q;

   assert_no_req_boot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_q |-> !req_o);

   assert_start_granted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_q && $rose(own_q)) |-> $past(take_o));

   assert_recov_min_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ras_n_q) |=> ras_n_q);

   assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

endmodule

// File: rtl/drf_refresh_seq.sv
module drf_refresh_seq
   import drf_pkg::*;
#(
   parameter ref_style_e  STYLE       = REF_ROW,
   parameter int unsigned CLK_MHZ     = 125,
   parameter int unsigned STARTUP_US  = 100,
   parameter int unsigned REFRESH_NS  = 15600,
   parameter int unsigned TRC_NS      = 65,
   parameter int unsigned LEAD_CYC    = 1,
   parameter int unsigned LOW_CYC     = 5,
   parameter int unsigned REC_CYC     = 4,
   parameter int unsigned INIT_CYCLES = 8,
   parameter int unsigned PEND_MAX    = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned ROW_W       = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              grant_i,
   output logic              req_o,
   output logic              own_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe_o,
   output logic              init_done_o,
   output logic              ref_done_o
);
   localparam int unsigned STARTUP_CYC  = CLK_MHZ * STARTUP_US + 1;
   localparam int unsigned INTERVAL_CYC = CLK_MHZ * REFRESH_NS / 1000;

   initial begin : elab_checks
      assert (ROW_W >= 1 && ROW_W <= ADDR_W) else $error("row width out of range");
      assert (LEAD_CYC >= 1 && LOW_CYC >= 2 && REC_CYC >= 2) else $error("phase too short");
      assert ((LOW_CYC + REC_CYC) * 1000 >= TRC_NS * CLK_MHZ) else $error("cycle time too short");
      assert (REFRESH_NS * 256 <= 4_000_000) else $error("refresh interval too long");
      assert (INTERVAL_CYC > LEAD_CYC + LOW_CYC + REC_CYC) else $error("interval too short");
      assert (PEND_MAX >= 1 && INIT_CYCLES >= 1) else $error("bad count");
   end

   logic boot_tick, period_tick, booting, take, cycle_end, pend_nz;

   drf_interval_timer #(.LIMIT(STARTUP_CYC)) u_boot (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(booting), .tick_o(boot_tick));

   drf_interval_timer #(.LIMIT(INTERVAL_CYC)) u_period (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(init_done_o), .tick_o(period_tick));

   drf_pending #(.MAX(PEND_MAX)) u_pend (
      .clk_i(clk_i), .rst_ni(rst_ni), .add_i(period_tick), .take_i(take), .nz_o(pend_nz));

   drf_cycle_fsm #(
      .STYLE(STYLE), .LEAD_CYC(LEAD_CYC), .LOW_CYC(LOW_CYC),
      .REC_CYC(REC_CYC), .INIT_CYCLES(INIT_CYCLES)
   ) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .boot_tick_i(boot_tick), .grant_i(grant_i),
      .pend_nz_i(pend_nz), .booting_o(booting), .req_o(req_o), .take_o(take),
      .cycle_end_o(cycle_end), .own_o(own_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
      .done_o(ref_done_o), .init_done_o(init_done_o));

   generate
      if (STYLE == REF_ROW) begin : g_row
         logic [ROW_W-1:0] row;

         drf_row_counter #(.W(ROW_W)) u_row (
            .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cycle_end), .row_o(row));

         assign addr_o    = own_o ? ADDR_W'(row) : '0;
         assign addr_oe_o = own_o;

         assert_addr_setup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ras_n_o) |-> addr_oe_o && $stable(addr_o));

         assert_cas_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ras_n_o) |-> cas_n_o);
      end else begin : g_cbr
         assign addr_o    = '0;
         assign addr_oe_o = 1'b0;

         assert_cas_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ras_n_o) |-> !cas_n_o && $past(!cas_n_o));
      end
   endgenerate

   assert_idle_pins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !own_o |-> ras_n_o && cas_n_o && !addr_oe_o);

endmodule

// File: tb/drf_refresh_seq_tb.sv
`timescale 1ns/1ps
module drf_refresh_seq_tb_top;
   import drf_pkg::*;

   localparam int CLK_MHZ  = 125;
   localparam int S_CYC    = CLK_MHZ * 100 + 1;
   localparam int I_CYC    = CLK_MHZ * 15600 / 1000;
   localparam int LOW      = 5;
   localparam int PMAX     = 4;
   localparam int TRC_CYC  = (65 * CLK_MHZ + 999) / 1000;
   // {grant delay after request, expected refresh cycles in window}
   localparam int TBL [4][2] = '{'{0, 1}, '{5, 1}, '{I_CYC - 1, 2}, '{I_CYC + 100, 2}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // main unit: row-address style
   logic m_grant = 1'b0;
   logic m_req, m_own, m_ras, m_cas, m_oe, m_init, m_done;
   logic [7:0] m_addr;
   drf_refresh_seq #(.STYLE(REF_ROW), .CLK_MHZ(CLK_MHZ), .PEND_MAX(PMAX), .LOW_CYC(LOW))
   dut_i (.clk_i(clk), .rst_ni(rst_n), .grant_i(m_grant), .req_o(m_req), .own_o(m_own),
          .ras_n_o(m_ras), .cas_n_o(m_cas), .addr_o(m_addr), .addr_oe_o(m_oe),
          .init_done_o(m_init), .ref_done_o(m_done));

   // CAS-first style, always granted
   logic c_req, c_own, c_ras, c_cas, c_oe, c_init, c_done;
   logic [7:0] c_addr;
   drf_refresh_seq #(.STYLE(REF_CBR), .CLK_MHZ(CLK_MHZ))
   dut_cbr_i (.clk_i(clk), .rst_ni(rst_n), .grant_i(c_req), .req_o(c_req), .own_o(c_own),
              .ras_n_o(c_ras), .cas_n_o(c_cas), .addr_o(c_addr), .addr_oe_o(c_oe),
              .init_done_o(c_init), .ref_done_o(c_done));

   // narrow row counter, always granted, to see the wrap
   logic w_req, w_own, w_ras, w_cas, w_oe, w_init, w_done;
   logic [7:0] w_addr;
   drf_refresh_seq #(.STYLE(REF_ROW), .CLK_MHZ(CLK_MHZ), .ROW_W(3))
   dut_w_i (.clk_i(clk), .rst_ni(rst_n), .grant_i(w_req), .req_o(w_req), .own_o(w_own),
            .ras_n_o(w_ras), .cas_n_o(w_cas), .addr_o(w_addr), .addr_oe_o(w_oe),
            .init_done_o(w_init), .ref_done_o(w_done));

   // ---------------- monitors ----------------
   bit prev_ras_m = 1'b1, prev_done_m = 1'b0, cas_low_m = 1'b0, stray_m = 1'b0;
   int falls_m = 0, dones_m = 0, low_m = 0, gap_m = 0, min_gap_m = 1000000, exp_row = 0;
   bit prev_ras_c = 1'b1, prev_cas_c = 1'b1;
   int falls_c = 0;
   bit prev_ras_w = 1'b1;
   int falls_w = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ras_m && !m_ras) begin
            check(m_oe && int'(m_addr) == exp_row, "R7 row address at RAS fall", int'(m_addr), exp_row);
            exp_row = (exp_row + 1) % 256;
            if (falls_m > 0 && gap_m + 1 < min_gap_m) min_gap_m = gap_m + 1;
            gap_m = 0;
            falls_m++;
         end else gap_m++;
         if (!prev_ras_m && m_ras) check(low_m == LOW, "R9 RAS low width", low_m, LOW);
         low_m = m_ras ? 0 : low_m + 1;
         if (!m_cas) cas_low_m = 1'b1;
         if (!m_own && (!m_ras || !m_cas || m_oe)) stray_m = 1'b1;
         if (m_done) begin
            dones_m++;
            if (prev_done_m) check(1'b0, "R12 done longer than one clock", 2, 1);
         end
         prev_done_m = m_done;
         prev_ras_m  = m_ras;

         if (prev_ras_c && !c_ras) begin
            check(!prev_cas_c && !c_cas && !c_oe, "R6 CAS leads RAS, no address", int'(prev_cas_c), 0);
            falls_c++;
         end
         prev_ras_c = c_ras;
         prev_cas_c = c_cas;

         if (prev_ras_w && !w_ras) begin
            check(int'(w_addr) == falls_w % 8, "R8 narrow row sequence with wrap", int'(w_addr), falls_w % 8);
            falls_w++;
         end
         prev_ras_w = w_ras;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      wrap_up();
   end

   // ---------------- main sequence ----------------
   initial begin
      int n;
      repeat (5) step();
      // R1 reset state
      check(!m_own && !m_req && !m_init && !m_done && !m_oe && m_ras && m_cas,
            "R1 reset outputs idle", int'({m_own, m_req, m_init, m_done, m_oe, m_ras, m_cas}), 3);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 start-up delay
      n = 0;
      forever begin
         @(posedge clk); n++;
         @(negedge clk);
         if (m_own) break;
      end
      check(n == S_CYC, "R2 start-up wait in clocks", n, S_CYC);
      check(n * 8 > 100000, "R2 start-up wait over 100 us", n * 8, 100000);

      // R3 dummy cycles before init-done
      while (!m_init) begin
         check(!m_req, "R3 no request before init", int'(m_req), 0);
         step();
      end
      check(falls_m == 8, "R3 dummy cycle count", falls_m, 8);
      check(falls_c == 8, "R3 dummy cycle count CAS-first", falls_c, 8);

      // R4 first request after one interval
      n = 0;
      forever begin
         @(posedge clk); n++;
         @(negedge clk); #1;
         if (m_req) break;
      end
      check(n == I_CYC, "R4 first request spacing", n, I_CYC);
      check(I_CYC * 8 <= 15600, "R4 interval within 15.6 us", I_CYC * 8, 15600);

      // table of grant delays (R5, R10)
      for (int e = 0; e < 4; e++) begin
         int got;
         while (!m_req) step();
         repeat (TBL[e][0]) step();
         check(!m_own && m_ras, "R5 no cycle before grant", int'(m_own), 0);
         m_grant = 1'b1;
         got = 0;
         for (int k = 0; k < 120; k++) begin
            step();
            if (m_done) got++;
         end
         m_grant = 1'b0;
         check(got == TBL[e][1], "R10 cycles per grant window", got, TBL[e][1]);
         check(!m_req && !m_own, "R10 all slots consumed", int'(m_req), 0);
      end

      // R11 saturation of the pending count
      begin
         int got;
         while (!m_req) step();
         repeat ((PMAX + 1) * I_CYC + I_CYC / 2) step();
         m_grant = 1'b1;
         got = 0;
         for (int k = 0; k < 200; k++) begin
            step();
            if (m_done) got++;
         end
         m_grant = 1'b0;
         check(got == PMAX, "R11 burst length after saturation", got, PMAX);
         check(!m_req, "R11 request drops after burst", int'(m_req), 0);
      end

      repeat (20) step();
      check(!cas_low_m, "R7 CAS never low in row-address style", int'(cas_low_m), 0);
      check(!stray_m, "R5 pins idle when not owned", int'(stray_m), 0);
      check(min_gap_m >= TRC_CYC, "R9 RAS fall spacing", min_gap_m, TRC_CYC);
      check(dones_m == falls_m, "R12 one done per cycle", dones_m, falls_m);
      check(falls_w >= 9, "R8 narrow counter wrapped", falls_w, 9);
      wrap_up();
   end

endmodule